// File: doc/BRIEF.md
# Bulk Endpoint DMA Transfer Controller

The block moves 16-bit words between a USB bulk endpoint buffer and system memory. It issues one DMA request per word and waits for an acknowledge. For every acknowledged word it advances a memory address and lowers an internal remaining-byte counter. Software sets it up through a small write port. That port carries a control word, a byte-count value and a start address. Software can later clear the sticky status.

A transfer stops on the first of three events, and each one behaves differently:
- **Counter expiry.** The remaining-byte counter reaches zero while counter termination is selected.
- **Short packet.** On an OUT endpoint, with short-packet termination selected, the last word of a packet shorter than the maximum packet size has been moved.
- **Software disable.** Software clears the enable. This is silent: no status is set and no interrupt is raised.

The first two causes each latch their own status bit and hold the interrupt output high until software clears it. In the OUT direction the endpoint buffer is drained into memory. In the IN direction memory words are pushed into the buffer. The buffer reports whether it holds data or has free space, flags the last word of a packet, and gives the length of the packet at its head.

Top module: `bulk_dma_ctrl`

## Requirements
- R1: After reset the enable, the request, the memory address, the remaining count, both status bits and the interrupt are all 0.
- R2: A control write with enable=1 while the block is idle copies the byte-count register into the remaining counter. A byte-count write while enabled does not change the remaining counter.
- R3: dma_req rises only while enabled and the buffer is ready (OUT: buf_avail=1, IN: buf_space=1). It then stays high until an acknowledge is sampled, and it is never high while disabled.
- R4: Each acknowledged word adds 2 to mem_addr, lowers cnt_remain by 2 (saturating at 0) and gives exactly one buf_pop (OUT) or buf_push (IN) strobe. During that strobe, data passes unchanged from buf_rdata to mem_wdata (OUT) or from mem_rdata to buf_wdata (IN).
- R5: With counter termination selected, the transfer ends in one of two ways. Either an acknowledge brings the counter to 0, or the block is enabled with a count of 0, in which case it ends without any request. In both cases enable drops, sts_cnt_eot sets and irq rises, even if buffer data or space remains.
- R6: On an OUT endpoint with short-packet termination selected, the transfer ends on the acknowledge of a word that has buf_last=1 and buf_pkt_len below MAX_PKT (64). This sets sts_short_eot.
- R7: Full-length packets never end a transfer. Short-packet termination has no effect in the IN direction.
- R8: A control write with enable=0 ends the transfer on that edge. An acknowledge in the same cycle is ignored, no status bit sets and irq does not rise.
- R9: With counter termination selected and one byte remaining, the transfer is a single byte with mem_be=2'b01 (bit 0 is the low byte). The counter then goes to 0. All other transfers use mem_be=2'b11.
- R10: mem_addr keeps its value while disabled, including after any termination. An address write while enabled is ignored.
- R11: irq is high while either status bit is set and stays high until sts_clr. A status bit being set in the same cycle wins over the clear.
- R12: A 64-byte count with counter termination moves exactly 32 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_en | input | 1 | Control: DMA enable |
| cfg_cnt_eot | input | 1 | Control: end on counter expiry |
| cfg_short_eot | input | 1 | Control: end on short packet (OUT) |
| cfg_dir_in | input | 1 | Control: 1 = IN endpoint (memory to buffer) |
| cnt_wr | input | 1 | Byte-count register write strobe |
| cnt_wdata | input | CNT_W | Byte-count value |
| addr_wr | input | 1 | Start address write strobe |
| addr_wdata | input | ADDR_W | Start address |
| sts_clr | input | 1 | Clear both status bits |
| dma_req | output | 1 | Word transfer request |
| dma_ack | input | 1 | Word transfer acknowledge |
| mem_addr | output | ADDR_W | Current memory address |
| mem_be | output | DATA_W/8 | Byte valid strobes |
| mem_wdata | output | DATA_W | Word to memory (OUT) |
| mem_rdata | input | DATA_W | Word from memory (IN) |
| buf_avail | input | 1 | Buffer holds a word (OUT) |
| buf_rdata | input | DATA_W | Head word of the buffer |
| buf_last | input | 1 | Head word ends its packet |
| buf_pkt_len | input | $clog2(MAX_PKT+1) | Byte length of the head packet |
| buf_pop | output | 1 | Consume the head word |
| buf_space | input | 1 | Buffer can take a word (IN) |
| buf_wdata | output | DATA_W | Word into the buffer |
| buf_push | output | 1 | Write a word into the buffer |
| dma_en | output | 1 | Transfer active |
| cnt_remain | output | CNT_W | Remaining byte count |
| sts_cnt_eot | output | 1 | Sticky: ended on counter |
| sts_short_eot | output | 1 | Sticky: ended on short packet |
| irq | output | 1 | Interrupt |

## Verification
The assertions check several rules on every cycle:
- a request is held until acknowledged and never appears while disabled;
- every acknowledged word steps the address and the counter;
- a software disable leaves the block idle with no rising interrupt;
- the interrupt holds until cleared;
- the address holds while idle.

Other behaviours only the bench's scenarios can show. These are which event ended a transfer, the exact word count for a given length, the single-byte last transfer, a packet-length stop landing after exactly the right word, and the buffer data left behind after a counter stop. The bench's reference model follows every acknowledge and buffer update to expose these.

// File: rtl/bulk_dma_pkg.sv
package bulk_dma_pkg;

  typedef struct packed {
    logic cnt_eot;
    logic short_eot;
    logic dir_in;
  } dma_cfg_t;

  typedef struct packed {
    logic by_cnt;
    logic by_short;
  } dma_term_t;

endpackage

// File: rtl/bulk_dma_regs.sv
module bulk_dma_regs
  import bulk_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_cnt_eot,
  input  logic             cfg_short_eot,
  input  logic             cfg_dir_in,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             sts_clr,
  input  dma_term_t        term,
  output dma_cfg_t         cfg,
  output logic [CNT_W-1:0] cnt_load,
  output logic             sts_cnt,
  output logic             sts_short,
  output logic             irq
);

  logic sts_cnt_n;
  logic sts_short_n;

  always_comb begin
    sts_cnt_n   = sts_cnt;
    sts_short_n = sts_short;
    if (sts_clr) begin
      sts_cnt_n   = 1'b0;
      sts_short_n = 1'b0;
    end
    if (term.by_cnt)   sts_cnt_n   = 1'b1;
    if (term.by_short) sts_short_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      cnt_load  <= '0;
      sts_cnt   <= 1'b0;
      sts_short <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg.cnt_eot   <= cfg_cnt_eot;
        cfg.short_eot <= cfg_short_eot;
        cfg.dir_in    <= cfg_dir_in;
      end
      if (cnt_wr) cnt_load <= cnt_wdata;
      sts_cnt   <= sts_cnt_n;
      sts_short <= sts_short_n;
      irq       <= sts_cnt_n | sts_short_n;
    end
  end

endmodule

// File: rtl/bulk_dma_eot.sv
module bulk_dma_eot
  import bulk_dma_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_PKT = 64
) (
  input  logic                         en,
  input  logic                         req,
  input  logic                         ack_eff,
  input  logic                         sw_stop,
  input  dma_cfg_t                     cfg,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [CNT_W-1:0]             cnt_next,
  input  logic                         buf_last,
  input  logic [$clog2(MAX_PKT+1)-1:0] buf_pkt_len,
  output dma_term_t                    term
);

  localparam int LEN_W = $clog2(MAX_PKT+1);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_PKT);

  logic live;
  logic cnt_hit;
  logic short_hit;

  assign live = en & ~sw_stop;

  always_comb begin
    cnt_hit   = 1'b0;
    short_hit = 1'b0;
    if (live && cfg.cnt_eot) begin
      if (ack_eff && cnt_next == '0) cnt_hit = 1'b1;
      if (!req && cnt == '0)         cnt_hit = 1'b1;
    end
    if (live && cfg.short_eot && !cfg.dir_in && ack_eff &&
        buf_last && (buf_pkt_len < FULL_LEN))
      short_hit = 1'b1;
  end

  assign term.by_cnt   = cnt_hit;
  assign term.by_short = short_hit;

endmodule

// File: rtl/bulk_dma_engine.sv
module bulk_dma_engine
  import bulk_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic                cfg_en,
  input  dma_cfg_t            cfg,
  input  logic [CNT_W-1:0]    cnt_load,
  input  logic                addr_wr,
  input  logic [ADDR_W-1:0]   addr_wdata,
  input  logic                buf_avail,
  input  logic                buf_space,
  input  logic                dma_ack,
  input  dma_term_t           term,
  output logic                en,
  output logic                req,
  output logic [ADDR_W-1:0]   addr,
  output logic [CNT_W-1:0]    cnt,
  output logic [CNT_W-1:0]    cnt_next,
  output logic                ack_eff,
  output logic                sw_stop,
  output logic [DATA_W/8-1:0] be
);

  localparam int BYTES = DATA_W / 8;
  localparam logic [CNT_W-1:0]  STEP_C = CNT_W'(BYTES);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BYTES);

  logic ready;
  logic stop_any;
  logic idle_zero;

  assign sw_stop   = cfg_wr & ~cfg_en;
  assign ack_eff   = req & dma_ack & ~sw_stop;
  assign ready     = cfg.dir_in ? buf_space : buf_avail;
  assign stop_any  = term.by_cnt | term.by_short;
  assign idle_zero = cfg.cnt_eot & (cnt == '0);
  assign cnt_next  = (cnt >= STEP_C) ? (cnt - STEP_C) : '0;

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_be
      assign be[b] = ~cfg.cnt_eot | (cnt > CNT_W'(b));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      req  <= 1'b0;
      addr <= '0;
      cnt  <= '0;
    end else begin
      if (!en && addr_wr) addr <= addr_wdata;
      if (sw_stop) begin
        en  <= 1'b0;
        req <= 1'b0;
      end else begin
        if (ack_eff) begin
          addr <= addr + STEP_A;
          cnt  <= cnt_next;
          req  <= 1'b0;
        end
        if (stop_any) begin
          en  <= 1'b0;
          req <= 1'b0;
        end else if (en && !req && ready && !idle_zero) begin
          req <= 1'b1;
        end
        if (cfg_wr && cfg_en && !en) begin
          en  <= 1'b1;
          cnt <= cnt_load;
        end
      end
    end
  end

endmodule

// File: rtl/bulk_dma_ctrl.sv
module bulk_dma_ctrl
  import bulk_dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int MAX_PKT = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_wr,
  input  logic                         cfg_en,
  input  logic                         cfg_cnt_eot,
  input  logic                         cfg_short_eot,
  input  logic                         cfg_dir_in,
  input  logic                         cnt_wr,
  input  logic [CNT_W-1:0]             cnt_wdata,
  input  logic                         addr_wr,
  input  logic [ADDR_W-1:0]            addr_wdata,
  input  logic                         sts_clr,
  output logic                         dma_req,
  input  logic                         dma_ack,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W/8-1:0]          mem_be,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  input  logic                         buf_avail,
  input  logic [DATA_W-1:0]            buf_rdata,
  input  logic                         buf_last,
  input  logic [$clog2(MAX_PKT+1)-1:0] buf_pkt_len,
  output logic                         buf_pop,
  input  logic                         buf_space,
  output logic [DATA_W-1:0]            buf_wdata,
  output logic                         buf_push,
  output logic                         dma_en,
  output logic [CNT_W-1:0]             cnt_remain,
  output logic                         sts_cnt_eot,
  output logic                         sts_short_eot,
  output logic                         irq
);

  dma_cfg_t         cfg;
  dma_term_t        term;
  logic [CNT_W-1:0] cnt_load;
  logic [CNT_W-1:0] cnt_next;
  logic             ack_eff;
  logic             sw_stop;

  bulk_dma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_cnt_eot   (cfg_cnt_eot),
    .cfg_short_eot (cfg_short_eot),
    .cfg_dir_in    (cfg_dir_in),
    .cnt_wr        (cnt_wr),
    .cnt_wdata     (cnt_wdata),
    .sts_clr       (sts_clr),
    .term          (term),
    .cfg           (cfg),
    .cnt_load      (cnt_load),
    .sts_cnt       (sts_cnt_eot),
    .sts_short     (sts_short_eot),
    .irq           (irq)
  );

  bulk_dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_en     (cfg_en),
    .cfg        (cfg),
    .cnt_load   (cnt_load),
    .addr_wr    (addr_wr),
    .addr_wdata (addr_wdata),
    .buf_avail  (buf_avail),
    .buf_space  (buf_space),
    .dma_ack    (dma_ack),
    .term       (term),
    .en         (dma_en),
    .req        (dma_req),
    .addr       (mem_addr),
    .cnt        (cnt_remain),
    .cnt_next   (cnt_next),
    .ack_eff    (ack_eff),
    .sw_stop    (sw_stop),
    .be         (mem_be)
  );

  bulk_dma_eot #(.CNT_W(CNT_W), .MAX_PKT(MAX_PKT)) u_eot (
    .en          (dma_en),
    .req         (dma_req),
    .ack_eff     (ack_eff),
    .sw_stop     (sw_stop),
    .cfg         (cfg),
    .cnt         (cnt_remain),
    .cnt_next    (cnt_next),
    .buf_last    (buf_last),
    .buf_pkt_len (buf_pkt_len),
    .term        (term)
  );

  assign buf_pop   = ack_eff & ~cfg.dir_in;
  assign buf_push  = ack_eff &  cfg.dir_in;
  assign mem_wdata = buf_rdata;
  assign buf_wdata = mem_rdata;

endmodule

// File: rtl/bulk_dma_ctrl_chk.sv
module bulk_dma_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              cfg_en,
  input logic              addr_wr,
  input logic              sts_clr,
  input logic              dma_req,
  input logic              dma_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  cnt_remain,
  input logic              dma_en,
  input logic              irq
);

  localparam int BYTES = DATA_W / 8;

  logic stop_w;
  assign stop_w = cfg_wr & ~cfg_en;

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> dma_en); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_ack && !stop_w |=> dma_req); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    dma_req && dma_ack && !stop_w |=> mem_addr == $past(mem_addr) + ADDR_W'(BYTES)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    dma_req && dma_ack && !stop_w |=>
      cnt_remain == (($past(cnt_remain) >= CNT_W'(BYTES)) ?
                     $past(cnt_remain) - CNT_W'(BYTES) : '0)); // R4
  AST_SW_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> !dma_req && !dma_en && !$rose(irq)); // R8
  AST_ADDR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dma_en && !addr_wr |=> $stable(mem_addr)); // R10
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq && !sts_clr |=> irq); // R11

endmodule

bind bulk_dma_ctrl bulk_dma_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_en     (cfg_en),
  .addr_wr    (addr_wr),
  .sts_clr    (sts_clr),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack),
  .mem_addr   (mem_addr),
  .cnt_remain (cnt_remain),
  .dma_en     (dma_en),
  .irq        (irq)
);

// File: tb/bulk_dma_ctrl_tb.sv
module bulk_dma_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_en = 0, cfg_cnt_eot = 0, cfg_short_eot = 0, cfg_dir_in = 0;
  logic        cnt_wr = 0;
  logic [15:0] cnt_wdata = 0;
  logic        addr_wr = 0;
  logic [31:0] addr_wdata = 0;
  logic        sts_clr = 0;
  logic        dma_req, dma_ack = 0;
  logic [31:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic        buf_avail = 0;
  logic [15:0] buf_rdata = 0;
  logic        buf_last = 0;
  logic [6:0]  buf_pkt_len = 0;
  logic        buf_pop, buf_space = 0, buf_push;
  logic [15:0] buf_wdata;
  logic        dma_en;
  logic [15:0] cnt_remain;
  logic        sts_cnt_eot, sts_short_eot, irq;

  always #5 clk = ~clk;

  bulk_dma_ctrl dut_i (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  bit m_en, m_req, m_ce, m_se, m_di, m_sc, m_ss, m_irq;
  int unsigned m_addr, m_cnt, m_creg;
  int q[$];
  int head_rem = 0;
  int space = 0;
  int n_xfer = 0;
  int last_be = 0;
  int word_ctr = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic add_pkt(int len);
    q.push_back(len);
    if (q.size() == 1) head_rem = len;
  endtask

  // reference model, evaluated on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_en = 0; m_req = 0; m_addr = 0; m_cnt = 0; m_creg = 0;
      m_ce = 0; m_se = 0; m_di = 0; m_sc = 0; m_ss = 0; m_irq = 0;
    end else begin
      bit dis, ack, rdy, tc, ts, n_en, n_req, n_sc, n_ss;
      int unsigned nc, n_addr, n_cnt;
      dis = cfg_wr && !cfg_en;
      ack = m_req && dma_ack && !dis;
      nc  = (m_cnt >= 2) ? m_cnt - 2 : 0;
      rdy = m_di ? buf_space : buf_avail;
      tc  = !dis && m_en && m_ce && ((ack && nc == 0) || (!m_req && m_cnt == 0));
      ts  = !dis && m_en && m_se && !m_di && ack && buf_last && (buf_pkt_len < 64);
      n_en = m_en; n_req = m_req; n_addr = m_addr; n_cnt = m_cnt;
      if (!m_en && addr_wr) n_addr = addr_wdata;
      if (dis) begin
        n_en = 0; n_req = 0;
      end else begin
        if (ack) begin n_addr = m_addr + 2; n_cnt = nc; n_req = 0; end
        if (tc || ts) begin n_en = 0; n_req = 0; end
        else if (m_en && !m_req && rdy && !(m_ce && m_cnt == 0)) n_req = 1;
        if (cfg_wr && cfg_en && !m_en) begin n_en = 1; n_cnt = m_creg; end
      end
      n_sc = sts_clr ? 0 : m_sc;
      n_ss = sts_clr ? 0 : m_ss;
      if (tc) n_sc = 1;
      if (ts) n_ss = 1;
      if (ack) begin
        n_xfer++;
        last_be = (m_ce && m_cnt == 1) ? 1 : 3;
        if (m_di) begin
          if (space > 0) space--;
        end else begin
          head_rem -= 2;
          word_ctr++;
          if (head_rem <= 0 && q.size() > 0) begin
            void'(q.pop_front());
            head_rem = (q.size() > 0) ? q[0] : 0;
          end
        end
      end
      if (cfg_wr) begin m_ce = cfg_cnt_eot; m_se = cfg_short_eot; m_di = cfg_dir_in; end
      if (cnt_wr) m_creg = cnt_wdata;
      m_en = n_en; m_req = n_req; m_addr = n_addr; m_cnt = n_cnt & 16'hffff;
      m_sc = n_sc; m_ss = n_ss; m_irq = n_sc | n_ss;
    end
  end

  // compare on every falling edge, then drive responder inputs
  always @(negedge clk) begin
    if (!rst) begin
      chk(dma_req == m_req, "R3 dma_req", dma_req, m_req);
      chk(mem_addr == m_addr, "R4 mem_addr", mem_addr, m_addr);
      chk(cnt_remain == m_cnt, "R4 cnt_remain", cnt_remain, m_cnt);
      chk(dma_en == m_en, "R5 dma_en", dma_en, m_en);
      chk(sts_cnt_eot == m_sc, "R5 sts_cnt_eot", sts_cnt_eot, m_sc);
      chk(sts_short_eot == m_ss, "R6 sts_short_eot", sts_short_eot, m_ss);
      chk(irq == m_irq, "R11 irq", irq, m_irq);
      if (m_req) chk(mem_be == ((m_ce && m_cnt == 1) ? 2'b01 : 2'b11), "R9 mem_be",
                     mem_be, (m_ce && m_cnt == 1) ? 1 : 3);
    end
    buf_avail   = q.size() > 0;
    buf_pkt_len = (q.size() > 0) ? 7'(q[0]) : 7'd0;
    buf_last    = (q.size() > 0) && head_rem <= 2;
    buf_rdata   = 16'(word_ctr * 16'h0101 + 16'h00a5);
    buf_space   = space > 0;
    mem_rdata   = 16'(m_addr) ^ 16'h5a5a;
    dma_ack     = m_req && (cyc % 3 != 1);
    #1;
    if (!rst) begin
      bit exp_x;
      exp_x = m_req && dma_ack && !(cfg_wr && !cfg_en);
      chk(buf_pop == (exp_x && !m_di), "R4 buf_pop", buf_pop, exp_x && !m_di);
      chk(buf_push == (exp_x && m_di), "R4 buf_push", buf_push, exp_x && m_di);
      if (buf_pop)  chk(mem_wdata == buf_rdata, "R4 mem_wdata", mem_wdata, buf_rdata);
      if (buf_push) chk(buf_wdata == mem_rdata, "R4 buf_wdata", buf_wdata, mem_rdata);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_cfg(bit en, bit ce, bit se, bit di);
    @(negedge clk);
    cfg_wr = 1; cfg_en = en; cfg_cnt_eot = ce; cfg_short_eot = se; cfg_dir_in = di;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic setup(int cnt, int addr);
    @(negedge clk);
    cnt_wr = 1; cnt_wdata = 16'(cnt); addr_wr = 1; addr_wdata = addr;
    @(negedge clk);
    cnt_wr = 0; addr_wr = 0;
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_clr = 1;
    @(negedge clk); sts_clr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && m_en; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dma_en == 0 && dma_req == 0 && irq == 0, "R1 ctl", {dma_en, dma_req, irq}, 0);
    chk(mem_addr == 0 && cnt_remain == 0, "R1 regs", mem_addr, 0);
    chk(sts_cnt_eot == 0 && sts_short_eot == 0, "R1 sts", {sts_cnt_eot, sts_short_eot}, 0);
    rst = 0;

    // counter stop, 64 bytes -> 32 words, data left in buffer
    add_pkt(64); add_pkt(64);
    setup(64, 32'h1000);
    n_xfer = 0;
    set_cfg(1, 1, 0, 0);
    chk(cnt_remain == 64, "R2 load", cnt_remain, 64);
    wait_idle();
    chk(n_xfer == 32, "R12 words", n_xfer, 32);
    chk(mem_addr == 32'h1040, "R10 final addr", mem_addr, 32'h1040);
    chk(sts_cnt_eot && !sts_short_eot && irq, "R5 cause", {sts_cnt_eot, sts_short_eot}, 2);
    chk(q.size() == 1, "R5 data left", q.size(), 1);
    repeat (4) @(negedge clk);
    chk(irq == 1, "R11 hold", irq, 1);
    clear_sts();
    chk(irq == 0, "R11 clear", irq, 0);
    q.delete(); head_rem = 0;

    // short packet stop, full packet passes
    add_pkt(64); add_pkt(10); add_pkt(64);
    setup(200, 32'h3000);
    n_xfer = 0;
    set_cfg(1, 0, 1, 0);
    wait_idle();
    chk(n_xfer == 37, "R7 full pkt passes", n_xfer, 37);
    chk(mem_addr == 32'h3000 + 74, "R6 addr", mem_addr, 32'h3000 + 74);
    chk(sts_short_eot && !sts_cnt_eot, "R6 cause", {sts_cnt_eot, sts_short_eot}, 1);
    chk(cnt_remain == 126, "R6 cnt", cnt_remain, 126);
    clear_sts();
    q.delete(); head_rem = 0;

    // IN with odd count: last single byte, short flag ignored
    space = 20;
    setup(7, 32'h4000);
    n_xfer = 0;
    set_cfg(1, 1, 1, 1);
    wait_idle();
    chk(n_xfer == 4, "R9 words", n_xfer, 4);
    chk(last_be == 1, "R9 last be", last_be, 1);
    chk(cnt_remain == 0, "R9 no wrap", cnt_remain, 0);
    chk(space == 16, "R5 stop mid buffer", space, 16);
    chk(sts_cnt_eot && !sts_short_eot, "R7 IN short ignored", {sts_cnt_eot, sts_short_eot}, 2);
    clear_sts();
    space = 0;

    // software disable, ignored writes while enabled
    add_pkt(64); add_pkt(64);
    setup(100, 32'h2000);
    set_cfg(1, 0, 0, 0);
    repeat (10) @(negedge clk);
    cnt_wr = 1; cnt_wdata = 16'd4; addr_wr = 1; addr_wdata = 32'h9998;
    @(negedge clk);
    cnt_wr = 0; addr_wr = 0;
    chk(cnt_remain != 4 && cnt_remain == m_cnt, "R2 no reload", cnt_remain, m_cnt);
    chk(mem_addr != 32'h9998, "R10 addr write ignored", mem_addr, m_addr);
    repeat (5) @(negedge clk);
    set_cfg(0, 0, 0, 0);
    chk(!dma_en && !dma_req, "R8 stopped", {dma_en, dma_req}, 0);
    chk(!irq && !sts_cnt_eot && !sts_short_eot, "R8 no irq", irq, 0);
    repeat (5) @(negedge clk);
    chk(!dma_req && !irq, "R8 stays idle", dma_req, 0);
    q.delete(); head_rem = 0;

    // zero count with counter stop: ends without a request
    add_pkt(64);
    setup(0, 32'h5000);
    n_xfer = 0;
    set_cfg(1, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk(n_xfer == 0 && !dma_en, "R5 zero count", n_xfer, 0);
    chk(sts_cnt_eot && irq, "R5 zero count sts", sts_cnt_eot, 1);
    chk(mem_addr == 32'h5000, "R10 addr kept", mem_addr, 32'h5000);
    clear_sts();
    q.delete(); head_rem = 0;

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule